// File: doc/BRIEF.md
# Counter-Array Timebase with Prescaler

This block is the shared time reference for an array of capture/compare channels. It selects one of five counting sources, passes it through a programmable prescaler and drives a 16-bit up-counter. The counter wraps at a programmable upper limit. The channels read the count value and the wrap event. Software reads the count, the overflow flag and the prescaler's live state.

Any source other than the bus clock is first halved, so that only every second event reaches the prescaler. The prescaler counts down from its divisor to 1. It issues a tick on the source event that finds it at 1, and then reloads. Each tick advances the counter. When the counter is at its limit, the next tick returns it to zero and raises a one-cycle wrap event. That event sets a sticky flag. The flag raises the interrupt line only while the interrupt enable is high.

Counting runs only while the run control is high. While the processor is held in debug, counting also needs the debug-run mode bit. Software may write the counter at any time, and that write takes precedence over a tick in the same cycle.

Top module: `pca_timebase`

## Requirements
- R1: After a synchronous reset, the count reads 0, the wrap event, flag and interrupt read 0, and the prescaler count reads 1.
- R2: The 3-bit source select is decoded as follows. Value 0 counts every bus clock. 1 counts every second timer-overflow pulse. 2 counts every second falling edge of the external count input. 3 counts every second oscillator tick pulse. 4 counts every second transition of the external count input. Values 5 to 7 count nothing.
- R3: The prescaler count steps down by one on each source event. On a source event that finds it at 1, it issues one counter tick and reloads the divisor. A divisor of 0 acts as 1024, and the count then reads back as 0 while it holds 1024.
- R4: The phase output is 0 while the prescaler's effective count exceeds half the effective divisor, and 1 otherwise.
- R5: Each prescaler tick adds one to the counter. A tick at the limit loads 0 instead. The wrap event is then high for exactly the one cycle in which the count first reads 0.
- R6: A limit of 0 means full scale, so the counter wraps after 0xFFFF. A counter written above its limit counts up to 0xFFFF and then wraps with a wrap event.
- R7: The wrap event sets the overflow flag on the following cycle. A clear pulse drops the flag, but a simultaneous wrap event wins. The interrupt line is the flag gated by the enable.
- R8: With run low, the halver, the prescaler and the counter all hold.
- R9: With debug halt high and the debug-run mode bit 0, counting holds. With the mode bit 1, counting continues.
- R10: A counter write loads the written value on the next cycle. It overrides any tick in the same cycle and produces no wrap event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Counter run enable |
| dbg_halt_i | input | 1 | Processor halted in debug |
| dbg_run_i | input | 1 | 1: keep counting during debug halt |
| src_sel_i | input | 3 | Counting source select |
| divisor_i | input | 10 | Prescaler divisor, 0 means 1024 |
| limit_i | input | 16 | Counter upper limit, 0 means 0xFFFF |
| tmr_ovf_i | input | 1 | Timer low-byte overflow pulse |
| ext_cnt_i | input | 1 | External count input level |
| osc_tick_i | input | 1 | External oscillator tick pulse |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write value |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_clr_i | input | 1 | Overflow flag clear pulse |
| count_o | output | 16 | Counter value |
| ovf_evt_o | output | 1 | One-cycle wrap event |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |
| div_count_o | output | 10 | Live prescaler count |
| div_phase_o | output | 1 | Prescaler half-cycle phase |

## Verification
The assertions assume that the external inputs are already synchronous to the bus clock. They also assume that the timer-overflow and oscillator inputs are pulses, at most one cycle wide, and that the divisor and limit stay steady while a count sequence is being checked. The stimulus changes every input only on the falling clock edge. It drives each pulse for one cycle, with an idle gap after it. It moves the external count level no faster than once every two cycles. Divisor, limit and source changes are made only after a reset or while the counter is stopped.

// File: rtl/pcat_pkg.sv
package pcat_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int DIV_W_DEF = 10;
    localparam int SEL_W     = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_BUS      = 3'd0,
        SRC_TMR      = 3'd1,
        SRC_EXT_FALL = 3'd2,
        SRC_OSC      = 3'd3,
        SRC_EXT_ANY  = 3'd4
    } src_e;

    typedef struct packed {
        logic tmr;
        logic ext_fall;
        logic osc;
        logic ext_any;
    } src_evt_t;

    function automatic logic src_halved(input src_e s);
        return (s == SRC_TMR) || (s == SRC_EXT_FALL) ||
               (s == SRC_OSC) || (s == SRC_EXT_ANY);
    endfunction

endpackage

// File: rtl/pcat_src.sv
module pcat_src
    import pcat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tmr_ovf_i,
    input  logic             ext_cnt_i,
    input  logic             osc_i,
    output logic             tick_o
);
    src_e     sel;
    src_evt_t ev;
    logic     ext_q;
    logic     half_q;
    logic     raw;
    logic     halved;

    assign sel = src_e'(sel_i);

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_cnt_i;
    end

    always_comb begin
        ev.tmr      = tmr_ovf_i;
        ev.ext_fall = ext_q & ~ext_cnt_i;
        ev.osc      = osc_i;
        ev.ext_any  = ext_q ^ ext_cnt_i;
    end

    always_comb begin
        case (sel)
            SRC_BUS:      raw = 1'b1;
            SRC_TMR:      raw = ev.tmr;
            SRC_EXT_FALL: raw = ev.ext_fall;
            SRC_OSC:      raw = ev.osc;
            SRC_EXT_ANY:  raw = ev.ext_any;
            default:      raw = 1'b0;
        endcase
    end

    assign halved = src_halved(sel);

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= 1'b0;
        else if (active_i && halved && raw)
            half_q <= ~half_q;
    end

    assign tick_o = active_i & raw & (~halved | half_q);

    // R2
    halved_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (halved && tick_o) |=> !(tick_o && $stable(sel_i)));

    // R8
    halver_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> $stable(half_q));

endmodule

// File: rtl/pcat_prescaler.sv
module pcat_prescaler #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_tick_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             div_tick_o,
    output logic [DIV_W-1:0] count_o,
    output logic             phase_o
);
    localparam logic [DIV_W:0] FULL = {1'b1, {DIV_W{1'b0}}};

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   eff_n;
    logic [DIV_W:0]   eff_cnt;
    logic             at_one;

    assign at_one  = (cnt_q == DIV_W'(1));
    assign eff_n   = (divisor_i == '0) ? FULL : {1'b0, divisor_i};
    assign eff_cnt = (cnt_q == '0) ? FULL : {1'b0, cnt_q};

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= DIV_W'(1);
        else if (src_tick_i) begin
            if (at_one) cnt_q <= divisor_i;
            else        cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign div_tick_o = src_tick_i & at_one;
    assign count_o    = cnt_q;
    assign phase_o    = (eff_cnt <= (eff_n >> 1));

    // R3
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !src_tick_i |=> $stable(cnt_q));

    // R3
    pre_reload_chk: assert property (@(posedge clk) disable iff (rst)
        div_tick_o |=> cnt_q == $past(divisor_i));

endmodule

// File: rtl/pcat_counter.sv
module pcat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;
    logic             evt_q;
    logic             wrap;

    assign lim_eff = (limit_i == '0) ? '1 : limit_i;
    assign wrap    = (cnt_q == lim_eff) || (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (wr_i)
                cnt_q <= wdata_i;
            else if (tick_i) begin
                if (wrap) begin
                    cnt_q <= '0;
                    evt_q <= 1'b1;
                end else
                    cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt_o = cnt_q;
    assign evt_o = evt_q;

    // R5
    evt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> cnt_q == '0);

    // R10
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (cnt_q == $past(wdata_i)) && !evt_q);

    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pcat_flag.sv
module pcat_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (evt_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_i;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> flag_q);

    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt_i) |=> !flag_q);

endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
    import pcat_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             dbg_halt_i,
    input  logic             dbg_run_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             tmr_ovf_i,
    input  logic             ext_cnt_i,
    input  logic             osc_tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             ovf_ie_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_evt_o,
    output logic             ovf_flag_o,
    output logic             irq_o,
    output logic [DIV_W-1:0] div_count_o,
    output logic             div_phase_o
);
    logic active;
    logic src_tick;
    logic div_tick;

    assign active = run_i & ~(dbg_halt_i & ~dbg_run_i);

    pcat_src u_src (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .sel_i     (src_sel_i),
        .tmr_ovf_i (tmr_ovf_i),
        .ext_cnt_i (ext_cnt_i),
        .osc_i     (osc_tick_i),
        .tick_o    (src_tick)
    );

    pcat_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .src_tick_i (src_tick),
        .divisor_i  (divisor_i),
        .div_tick_o (div_tick),
        .count_o    (div_count_o),
        .phase_o    (div_phase_o)
    );

    pcat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (div_tick),
        .limit_i (limit_i),
        .wr_i    (cnt_wr_i),
        .wdata_i (cnt_wdata_i),
        .cnt_o   (count_o),
        .evt_o   (ovf_evt_o)
    );

    pcat_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (ovf_evt_o),
        .clr_i  (ovf_clr_i),
        .ie_i   (ovf_ie_i),
        .flag_o (ovf_flag_o),
        .irq_o  (irq_o)
    );

    // R9
    dbg_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt_i && !dbg_run_i && !cnt_wr_i) |=> $stable(count_o) && $stable(div_count_o));

    // R8
    stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !cnt_wr_i) |=> $stable(count_o) && !ovf_evt_o);

endmodule

// File: tb/test_pca_timebase.sv
module test_pca_timebase;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 0, dbg_halt_i = 0, dbg_run_i = 0;
    logic [2:0]  src_sel_i = 0;
    logic [9:0]  divisor_i = 10'd1;
    logic [15:0] limit_i = 0;
    logic        tmr_ovf_i = 0, ext_cnt_i = 0, osc_tick_i = 0;
    logic        cnt_wr_i = 0;
    logic [15:0] cnt_wdata_i = 0;
    logic        ovf_ie_i = 0, ovf_clr_i = 0;
    logic [15:0] count_o;
    logic        ovf_evt_o, ovf_flag_o, irq_o;
    logic [9:0]  div_count_o;
    logic        div_phase_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int c0;
    int exp_q[$];

    pca_timebase i_pca_timebase (
        .clk(clk), .rst(rst), .run_i(run_i), .dbg_halt_i(dbg_halt_i),
        .dbg_run_i(dbg_run_i), .src_sel_i(src_sel_i), .divisor_i(divisor_i),
        .limit_i(limit_i), .tmr_ovf_i(tmr_ovf_i), .ext_cnt_i(ext_cnt_i),
        .osc_tick_i(osc_tick_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .ovf_ie_i(ovf_ie_i), .ovf_clr_i(ovf_clr_i), .count_o(count_o),
        .ovf_evt_o(ovf_evt_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o),
        .div_count_o(div_count_o), .div_phase_o(div_phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; run_i = 0; dbg_halt_i = 0; dbg_run_i = 0;
        src_sel_i = 0; divisor_i = 10'd1; limit_i = 0;
        tmr_ovf_i = 0; ext_cnt_i = 0; osc_tick_i = 0;
        cnt_wr_i = 0; ovf_ie_i = 0; ovf_clr_i = 0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic pulse_tmr();
        tmr_ovf_i = 1; step(1); tmr_ovf_i = 0; step(1);
    endtask

    task automatic pulse_osc();
        osc_tick_i = 1; step(1); osc_tick_i = 0; step(1);
    endtask

    // Scoreboard monitor: wrap events must appear in the expected cycles (R5)
    always @(negedge clk) begin
        if (!rst && ovf_evt_o) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected wrap event", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R5 wrap event cycle", cyc, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(1);
        do_reset();
        // R1 reset state
        check("R1 count", count_o, 0);
        check("R1 event", ovf_evt_o, 0);
        check("R1 flag", ovf_flag_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 div count", div_count_o, 1);

        // R5 R7: bus clock, divisor 1, limit 4
        limit_i = 16'd4; run_i = 1; c0 = cyc;
        exp_q.push_back(c0 + 5); exp_q.push_back(c0 + 10);
        step(3);
        check("R5 count mid", count_o, 3);
        step(7);
        check("R5 count wrapped", count_o, 0);
        check("R7 flag set", ovf_flag_o, 1);
        check("R7 irq masked", irq_o, 0);
        run_i = 0; ovf_ie_i = 1;
        step(1);
        check("R7 irq enabled", irq_o, 1);
        ovf_clr_i = 1; step(1); ovf_clr_i = 0;
        check("R7 flag cleared", ovf_flag_o, 0);
        check("R7 irq cleared", irq_o, 0);

        // R6 R10: full-scale wrap, write priority
        do_reset();
        limit_i = 0; cnt_wr_i = 1; cnt_wdata_i = 16'hFFFD; run_i = 1; c0 = cyc;
        exp_q.push_back(c0 + 4);
        step(1); cnt_wr_i = 0;
        check("R10 write wins over tick", count_o, 16'hFFFD);
        step(2);
        check("R6 count at full scale", count_o, 16'hFFFF);
        step(1);
        check("R6 wrap to zero", count_o, 0);
        limit_i = 16'd10; cnt_wr_i = 1; cnt_wdata_i = 16'hFFFE; c0 = cyc;
        exp_q.push_back(c0 + 3);
        step(1); cnt_wr_i = 0;
        check("R10 write load", count_o, 16'hFFFE);
        step(2);
        check("R6 above-limit wrap", count_o, 0);
        run_i = 0; step(1);

        // R3 R4: divisor 4
        do_reset();
        divisor_i = 10'd4; limit_i = 0; run_i = 1;
        step(1);
        check("R3 first tick count", count_o, 1);
        check("R3 reload", div_count_o, 4);
        check("R4 phase first half", div_phase_o, 0);
        step(1);
        check("R3 down count", div_count_o, 3);
        step(1);
        check("R4 phase second half", div_phase_o, 1);
        step(2);
        check("R3 second tick", count_o, 2);
        check("R3 reload again", div_count_o, 4);
        run_i = 0;

        // R3 R4: divisor 0 means 1024
        do_reset();
        divisor_i = 10'd0; run_i = 1;
        step(1);
        check("R3 full divisor reads 0", div_count_o, 0);
        check("R4 phase full start", div_phase_o, 0);
        step(511);
        check("R3 full count 513", div_count_o, 513);
        check("R4 phase before half", div_phase_o, 0);
        step(1);
        check("R4 phase at half", div_phase_o, 1);
        step(511);
        check("R3 count before tick", count_o, 1);
        step(1);
        check("R3 count after 1024", count_o, 2);
        run_i = 0;

        // R2 source 1: timer overflow halved
        do_reset();
        src_sel_i = 3'd1; limit_i = 0; run_i = 1;
        pulse_tmr(); pulse_tmr(); pulse_tmr(); step(2);
        check("R2 timer halved 3 pulses", count_o, 1);
        pulse_tmr(); step(1);
        check("R2 timer halved 4 pulses", count_o, 2);

        // R2 source 3: oscillator halved
        do_reset();
        src_sel_i = 3'd3; run_i = 1;
        pulse_osc(); pulse_osc(); pulse_osc(); pulse_osc(); pulse_osc(); pulse_osc();
        check("R2 osc halved", count_o, 3);

        // R2 sources 2 and 4: external falling / any edge
        do_reset();
        src_sel_i = 3'd2; run_i = 1;
        ext_cnt_i = 1; step(2); ext_cnt_i = 0; step(2);
        ext_cnt_i = 1; step(2); ext_cnt_i = 0; step(2);
        check("R2 ext falling halved", count_o, 1);
        src_sel_i = 3'd4;
        ext_cnt_i = 1; step(2); ext_cnt_i = 0; step(2);
        check("R2 ext any edge halved", count_o, 2);

        // R2 unused select
        do_reset();
        src_sel_i = 3'd5; run_i = 1;
        pulse_osc(); pulse_tmr(); step(4);
        check("R2 unused select", count_o, 0);

        // R8 R9: run and debug
        do_reset();
        run_i = 1;
        step(5);
        check("R8 running", count_o, 5);
        run_i = 0; step(3);
        check("R8 stopped", count_o, 5);
        run_i = 1; dbg_halt_i = 1; dbg_run_i = 0; step(3);
        check("R9 halted in debug", count_o, 5);
        dbg_run_i = 1; step(3);
        check("R9 runs in debug", count_o, 8);
        run_i = 0; dbg_halt_i = 0; step(2);

        check("R5 all wrap events seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule